// File: doc/BRIEF.md
# Serial Receiver with Error Status

This block receives 8-bit serial characters, LSB first, with one start bit and one stop bit and no parity bit. It samples the line on an oversampling tick enable (OVS ticks per bit). A falling edge is taken as a start bit only after the line is checked again at mid-bit. Each finished character goes into an internal FIFO together with three flags: break, framing error and a parity flag. The parity flag is copied from an input at the stop-bit sample, so an external checker can supply it.

The host pulls characters with a read strobe. The FIFO shows its head at all times. Sticky status bits record break, framing, parity and overrun. The three character flags reach the status bits either when the character is read out (normal mode) or when it is written in (accumulate mode). Command strobes do the following:
- enable or disable the receiver;
- reset the receiver;
- clear the status bits;
- select the accumulate mode.

Disabling the receiver keeps the FIFO contents. Characters received after re-enabling are appended behind them.

Top module: `uart_rx_errstat`

## Requirements
- R1: A low line seen on a tick starts a frame only if the line is still low 8 ticks later (mid start bit). Otherwise it is a false start, no character is stored, and the search for a start bit begins again.
- R2: Data bits are sampled at mid-bit, LSB first, and the stop bit is then sampled at mid-bit. The entry is {brk, frm, par, data[7:0]}: frm=1 when the stop bit is 0, brk=1 when the stop bit is 0 and all data bits are 0, and par equals par_flag_in at the stop sample.
- R3: The FIFO holds DEPTH entries in arrival order. The head appears on rd_data/rd_brk/rd_frm/rd_par while rx_empty=0, and rd_stb pops it. A rd_stb while the FIFO is empty has no effect.
- R4: A character that completes while the FIFO is full is dropped, and st_ovr is set.
- R5: In normal mode (acc_val=0), st_brk/st_frm/st_par are OR-ed with the flags of each character when it is popped.
- R6: In accumulate mode (acc_stb with acc_val=1), those bits are OR-ed with the flags of each character when it is written.
- R7: err_clr_stb clears st_brk, st_frm, st_par and st_ovr on the next edge, taking priority over any set in the same cycle.
- R8: en_stb with en_val=0 aborts a partly received character at once. The FIFO contents and the status bits are kept. After re-enabling, new characters are appended behind the kept ones.
- R9: rx_rst_stb aborts any character in progress and empties the FIFO. Status bits and the enable are kept.
- R10: After reset the FIFO is empty, all status bits are 0, the receiver is disabled and normal mode is selected.
- R11: While the receiver is disabled, line activity stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversample tick enable |
| rxd | input | 1 | Serial line, idle high |
| par_flag_in | input | 1 | Parity flag captured with each character |
| en_stb | input | 1 | Strobe: load receiver enable from en_val |
| en_val | input | 1 | Enable value |
| rx_rst_stb | input | 1 | Strobe: reset receiver and empty FIFO |
| err_clr_stb | input | 1 | Strobe: clear status bits |
| acc_stb | input | 1 | Strobe: load accumulate mode from acc_val |
| acc_val | input | 1 | 1 = flags reach status on FIFO entry |
| rd_stb | input | 1 | Pop the FIFO head |
| rd_data | output | 8 | Head character |
| rd_brk | output | 1 | Head break flag |
| rd_frm | output | 1 | Head framing flag |
| rd_par | output | 1 | Head parity flag |
| rx_empty | output | 1 | FIFO empty |
| rx_full | output | 1 | FIFO full |
| st_brk | output | 1 | Sticky break status |
| st_frm | output | 1 | Sticky framing status |
| st_par | output | 1 | Sticky parity status |
| st_ovr | output | 1 | Sticky overrun status |

## Verification
The bench uses the defaults OVS=16 and DEPTH=16, and holds tick high on every clock, so each bit lasts 16 clocks and the mid-bit samples fall at fixed, known cycles. With a 16-entry FIFO, sixteen frames fill it and a seventeenth reaches the overrun drop. Along the way the bench also covers false starts, break frames, aborts mid-frame and the two flag-timing modes.

// File: rtl/uart_rx_errstat.sv
module uart_rx_errstat #(
  parameter int OVS   = 16,
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       par_flag_in,
  input  logic       en_stb,
  input  logic       en_val,
  input  logic       rx_rst_stb,
  input  logic       err_clr_stb,
  input  logic       acc_stb,
  input  logic       acc_val,
  input  logic       rd_stb,
  output logic [7:0] rd_data,
  output logic       rd_brk,
  output logic       rd_frm,
  output logic       rd_par,
  output logic       rx_empty,
  output logic       rx_full,
  output logic       st_brk,
  output logic       st_frm,
  output logic       st_par,
  output logic       st_ovr
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_st_t;

  rx_st_t         state;
  logic [CW-1:0]  cnt;
  logic [2:0]     nbit;
  logic [7:0]     shreg;
  logic           rx_en, acc_mode;
  logic [10:0]    mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [AW:0]    count;

  logic        abort, char_done, push, pop, ovr_set, last_tick;
  logic [10:0] entry, head;
  logic [2:0]  flag_set;

  assign abort     = rx_rst_stb | (en_stb & ~en_val);
  assign last_tick = tick & (cnt == CW'(OVS - 1));
  assign char_done = (state == S_STOP) & last_tick & ~abort;
  assign entry     = {~rxd & (shreg == 8'h00), ~rxd, par_flag_in, shreg};
  assign rx_empty  = (count == '0);
  assign rx_full   = (count == (AW+1)'(DEPTH));
  assign push      = char_done & ~rx_full;
  assign ovr_set   = char_done & rx_full;
  assign pop       = rd_stb & ~rx_empty & ~rx_rst_stb;
  assign head      = mem[rp];
  assign {rd_brk, rd_frm, rd_par, rd_data} = head;
  assign flag_set  = acc_mode ? (push ? entry[10:8] : 3'b000)
                              : (pop  ? head[10:8]  : 3'b000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en    <= 1'b0;
      acc_mode <= 1'b0;
    end else begin
      if (en_stb)  rx_en    <= en_val;
      if (acc_stb) acc_mode <= acc_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      nbit  <= '0;
      shreg <= '0;
    end else if (abort) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (tick) begin
      case (state)
        S_IDLE: if (rx_en && !rxd) begin
          state <= S_START;
          cnt   <= '0;
        end
        S_START: if (cnt == CW'(HALF - 1)) begin
          cnt  <= '0;
          nbit <= '0;
          state <= rxd ? S_IDLE : S_DATA;
        end else cnt <= cnt + 1'b1;
        S_DATA: if (last_tick) begin
          shreg <= {rxd, shreg[7:1]};
          cnt   <= '0;
          nbit  <= nbit + 1'b1;
          if (nbit == 3'd7) state <= S_STOP;
        end else cnt <= cnt + 1'b1;
        default: if (last_tick) begin
          state <= S_IDLE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (rx_rst_stb) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {st_brk, st_frm, st_par, st_ovr} <= '0;
    end else if (err_clr_stb) begin
      {st_brk, st_frm, st_par, st_ovr} <= '0;
    end else begin
      {st_brk, st_frm, st_par} <= {st_brk, st_frm, st_par} | flag_set;
      if (ovr_set) st_ovr <= 1'b1;
    end
  end

  assert_false_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START && tick && cnt == CW'(HALF - 1) && rxd && !abort) |=> state == S_IDLE);

  assert_drop_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_full && !pop && !rx_rst_stb && !err_clr_stb) |=> (st_ovr && rx_full));

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr_stb |=> !(st_brk || st_frm || st_par || st_ovr));

  assert_reset_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_stb |=> rx_empty);

  assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && state == S_IDLE) |=> state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst_n) assert_count_bound_R3: assert (count <= (AW+1)'(DEPTH));
  end
endmodule

// File: tb/uart_rx_errstat_test.sv
module uart_rx_errstat_test;
  localparam int CLK = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b1, rxd = 1'b1, par_flag_in = 1'b0;
  logic en_stb = 0, en_val = 0, rx_rst_stb = 0, err_clr_stb = 0;
  logic acc_stb = 0, acc_val = 0, rd_stb = 0;
  logic [7:0] rd_data;
  logic rd_brk, rd_frm, rd_par, rx_empty, rx_full;
  logic st_brk, st_frm, st_par, st_ovr;

  int compared = 0, mismatched = 0;
  logic [10:0] q[$];
  bit m_en = 0, m_acc = 0;
  bit [3:0] m_st = 0;  // {brk,frm,par,ovr}

  uart_rx_errstat #(.OVS(16), .DEPTH(DEPTH)) uut (.*);

  always #(CLK/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #(CLK/4);
      if (rst_n) begin
        check("R3 empty", rx_empty, q.size() == 0);
        check("R4 full", rx_full, q.size() == DEPTH);
        if (q.size() != 0)
          check("R2 head", {rd_brk, rd_frm, rd_par, rd_data}, q[0]);
        check("R5/R6/R7 status", {st_brk, st_frm, st_par, st_ovr}, m_st);
      end
    end
  end

  function automatic void model_push(logic [10:0] e);
    if (!m_en) return;
    if (q.size() == DEPTH) m_st[0] = 1'b1;
    else begin
      q.push_back(e);
      if (m_acc) m_st[3:1] = m_st[3:1] | e[10:8];
    end
  endfunction

  // op: 0 enable, 1 acc mode, 2 clear, 3 rx reset, 4 read
  task automatic command(int op, bit v);
    logic [10:0] e;
    @(negedge clk);
    case (op)
      0: begin en_stb = 1; en_val = v; end
      1: begin acc_stb = 1; acc_val = v; end
      2: err_clr_stb = 1;
      3: rx_rst_stb = 1;
      default: rd_stb = 1;
    endcase
    @(posedge clk);
    case (op)
      0: m_en = v;
      1: m_acc = v;
      2: m_st = 0;
      3: q.delete();
      default: if (q.size() != 0) begin
        e = q.pop_front();
        if (!m_acc) m_st[3:1] = m_st[3:1] | e[10:8];
      end
    endcase
    @(negedge clk);
    {en_stb, acc_stb, err_clr_stb, rx_rst_stb, rd_stb} = '0;
  endtask

  task automatic send_partial(logic [7:0] d, int nbits);
    @(negedge clk);
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      rxd = d[i];
      repeat (16) @(negedge clk);
    end
  endtask

  task automatic send_frame(logic [7:0] d, bit stopb, bit par);
    par_flag_in = par;
    send_partial(d, 8);
    rxd = stopb;
    repeat (8) @(negedge clk);
    @(posedge clk);
    model_push({~stopb & (d == 8'h00), ~stopb, par, d});
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    #(CLK * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset empty", rx_empty, 1);
    check("R10 reset status", {st_brk, st_frm, st_par, st_ovr}, 0);

    // R11: disabled receiver stores nothing
    send_frame(8'h5A, 1, 0);
    check("R11 disabled empty", rx_empty, 1);

    command(0, 1);
    send_frame(8'hA5, 1, 0);
    send_frame(8'h3C, 1, 1);
    check("R2 first char", rd_data, 8'hA5);
    check("R5 no status before read", st_par, 0);
    command(4, 0);
    check("R3 order", rd_data, 8'h3C);
    command(4, 0);
    check("R5 par set on read", st_par, 1);
    command(2, 0);
    check("R7 cleared", {st_brk, st_frm, st_par, st_ovr}, 0);

    // R1: short glitch is a false start
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (30) @(negedge clk);
    check("R1 false start ignored", rx_empty, 1);

    // R2: framing and break, normal mode
    send_frame(8'h81, 0, 0);
    send_frame(8'h00, 0, 0);
    check("R5 frm not yet", st_frm, 0);
    check("R2 frm flag", {rd_brk, rd_frm}, 2'b01);
    command(1, 1);
    send_frame(8'h00, 0, 1);
    check("R6 brk on entry", {st_brk, st_frm, st_par}, 3'b111);
    command(1, 0);
    command(4, 0);
    command(4, 0);
    check("R2 break flag popped", {rd_brk, rd_frm, rd_par}, 3'b111);
    command(4, 0);
    command(4, 0);  // R3 read on empty ignored
    check("R3 empty read", rx_empty, 1);
    command(2, 0);

    // R8: disable mid-frame keeps FIFO, appends after re-enable
    send_frame(8'h11, 1, 0);
    send_partial(8'h00, 3);
    command(0, 0);
    repeat (40) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    command(0, 1);
    send_frame(8'h77, 1, 0);
    check("R8 kept head", rd_data, 8'h11);
    command(4, 0);
    check("R8 appended", rd_data, 8'h77);
    command(4, 0);

    // R4: overrun
    for (int i = 0; i < DEPTH; i++) send_frame(8'(i + 8'h20), 1, 0);
    check("R4 full", rx_full, 1);
    send_frame(8'hEE, 1, 1);
    check("R4 ovr set", st_ovr, 1);
    check("R4 head kept", rd_data, 8'h20);

    // R9: reset mid-frame empties FIFO, keeps status
    send_partial(8'hFF, 2);
    command(3, 0);
    repeat (200) @(negedge clk);
    check("R9 empty", rx_empty, 1);
    check("R9 status kept", st_ovr, 1);
    command(2, 0);
    send_frame(8'h42, 1, 0);
    check("R9 receives after reset", rd_data, 8'h42);

    repeat (5) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule